// File: doc/BRIEF.md
# Wide Store Mask Classifier

This block sits beside a wide data-memory port and turns each access into one compact event. On the write side it inspects a 256-bit write word, a write mask with one enable bit per data bit, and a word address that counts 32-byte units. From the mask it decides whether the access stored the whole 256-bit line, stored exactly one aligned 32-bit chunk, or used a mask that fits neither shape. It then reports the matching byte address and payload. A whole-line store reports the full data at the line address. A chunk store reports the byte address of that chunk and its 32 data bits. A malformed mask is flagged as an error, and the full mask and full data are passed along.

Reads are always reported as whole-line loads at the line address, carrying the full 256-bit read data. Every event appears on a registered output one clock after the access, with a valid bit and a two-bit kind code. A monitor, trace writer or scoreboard can consume this stream without decoding masks itself. When a read and a write are strobed in the same cycle, the write wins and a collision flag is raised.

Top module: `dmem_wr_classify`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ev_valid_o` and `ev_collide_o` are 0.
- R2: A write whose mask is all ones is reported one cycle later with kind 2'd0 (full line). The byte address is the word address shifted left by 5, and the data is the full 256-bit write data.
- R3: A write whose mask sets every bit of exactly one aligned 32-bit chunk, and no other bit, is reported with kind 2'd1 (chunk store). Chunk k covers data bits 32k+31 down to 32k. The low 32 bits of `ev_data_o` hold that chunk's data, and all higher bits are 0.
- R4: For a chunk store, the reported byte address is (word address << 5) + 4*k.
- R5: Any other non-zero write mask is reported with kind 2'd2 (error). This includes partial chunks, several chunks and unaligned spans. The event carries the full mask on `ev_mask_o`, the full write data and the line address. For kinds other than error, `ev_mask_o` is 0.
- R6: A write strobe with an all-zero mask is reported as kind 2'd2 (error).
- R7: A read without a write is reported with kind 2'd3 (load). It carries the full 256-bit read data at the line address (word address << 5).
- R8: When the read and write strobes are both set, the write is classified and reported, and `ev_collide_o` is 1. Otherwise `ev_collide_o` is 0.
- R9: A cycle with neither strobe gives `ev_valid_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address in 32-byte units |
| wdata_i | input | DATA_W | Write data |
| wmask_i | input | DATA_W | Bit-level write enable mask |
| rdata_i | input | DATA_W | Read data, presented with the read strobe |
| ev_valid_o | output | 1 | Event valid |
| ev_kind_o | output | 2 | 0 full line, 1 chunk store, 2 error, 3 load |
| ev_addr_o | output | ADDR_W+5 | Byte address of the event |
| ev_data_o | output | DATA_W | Event data (chunk data zero-extended for a chunk store) |
| ev_mask_o | output | DATA_W | Full mask for an error event, else 0 |
| ev_collide_o | output | 1 | Read and write were strobed together |

## Verification
The bound checker watches every cycle for these properties:
- a full-ones mask, a zero mask and a plain read each produce the right kind in the following cycle;
- a chunk store never leaks data above bit 31 and always lands on a 4-byte-aligned address within the accessed line;
- an error event forwards exactly the mask and data it was given;
- a collision is only ever reported alongside a valid write event.

Two properties depend on the specific mask pattern: which chunk index a given mask selects, and whether a given near-miss pattern falls into the error class. Only the bench's sweeps can show these. The sweeps cover all 256 combinations of whole chunks, every single-bit hole and single-bit set in each chunk, and shifted 32-bit windows.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

   typedef enum logic [1:0] {
      EV_FULL = 2'd0,
      EV_WORD = 2'd1,
      EV_ERR  = 2'd2,
      EV_LOAD = 2'd3
   } ev_kind_e;

endpackage

// File: rtl/dwc_chunk_scan.sv
// Splits the bit mask into chunks and reports, per chunk, whether it is
// completely enabled and whether any bit in it is enabled.
module dwc_chunk_scan #(
   parameter int DATA_W  = 256,
   parameter int CHUNK_W = 32
) (
   input  logic [DATA_W-1:0]         mask_i,
   output logic [DATA_W/CHUNK_W-1:0] full_o,
   output logic [DATA_W/CHUNK_W-1:0] touch_o
);
   localparam int NCH = DATA_W / CHUNK_W;

   for (genvar g = 0; g < NCH; g++) begin : g_chunk
      logic [CHUNK_W-1:0] slice;
      assign slice      = mask_i[g*CHUNK_W +: CHUNK_W];
      assign full_o[g]  = &slice;
      assign touch_o[g] = |slice;
   end
endmodule

// File: rtl/dwc_onehot_index.sv
// Encodes the position of a set bit and tells whether exactly one bit is set.
module dwc_onehot_index #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             single_o
);
   logic [N-1:0] vec_less;

   assign vec_less = vec_i - N'(1);
   assign single_o = (vec_i != '0) && ((vec_i & vec_less) == '0);

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/dwc_classify.sv
// Chooses the event kind from the strobes and the per-chunk mask summary.
module dwc_classify
   import dwc_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic           wr_en_i,
   input  logic           rd_en_i,
   input  logic [NCH-1:0] full_i,
   input  logic [NCH-1:0] touch_i,
   input  logic           single_touch_i,
   output ev_kind_e       kind_o,
   output logic           valid_o,
   output logic           collide_o
);
   logic all_full;
   logic word_ok;

   assign all_full  = &full_i;
   assign word_ok   = single_touch_i && ((touch_i & ~full_i) == '0);
   assign valid_o   = wr_en_i | rd_en_i;
   assign collide_o = wr_en_i & rd_en_i;

   always_comb begin
      if (wr_en_i) begin
         if (all_full)     kind_o = EV_FULL;
         else if (word_ok) kind_o = EV_WORD;
         else              kind_o = EV_ERR;
      end else begin
         kind_o = EV_LOAD;
      end
   end
endmodule

// File: rtl/dwc_payload.sv
// Builds the byte address, data and mask that go with a classified event.
module dwc_payload
   import dwc_pkg::*;
#(
   parameter int DATA_W  = 256,
   parameter int CHUNK_W = 32,
   parameter int ADDR_W  = 10,
   parameter int IDX_W   = 3,
   parameter int OFFS_W  = 5,
   parameter int CB_SH   = 2
) (
   input  ev_kind_e                kind_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic [DATA_W-1:0]       wmask_i,
   input  logic [DATA_W-1:0]       rdata_i,
   output logic [ADDR_W+OFFS_W-1:0] baddr_o,
   output logic [DATA_W-1:0]       data_o,
   output logic [DATA_W-1:0]       mask_o
);
   logic [CHUNK_W-1:0] chunk;
   logic [OFFS_W-1:0]  offs;

   assign chunk = wdata_i[idx_i*CHUNK_W +: CHUNK_W];
   assign offs  = (kind_i == EV_WORD) ? (OFFS_W'(idx_i) << CB_SH) : '0;

   assign baddr_o = {addr_i, offs};

   always_comb begin
      unique case (kind_i)
         EV_WORD: data_o = DATA_W'(chunk);
         EV_LOAD: data_o = rdata_i;
         default: data_o = wdata_i;
      endcase
   end

   assign mask_o = (kind_i == EV_ERR) ? wmask_i : '0;
endmodule

// File: rtl/dmem_wr_classify.sv
module dmem_wr_classify
   import dwc_pkg::*;
#(
   parameter int DATA_W  = 256,
   parameter int CHUNK_W = 32,
   parameter int ADDR_W  = 10
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_en_i,
   input  logic                      rd_en_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [DATA_W-1:0]         wmask_i,
   input  logic [DATA_W-1:0]         rdata_i,
   output logic                      ev_valid_o,
   output logic [1:0]                ev_kind_o,
   output logic [ADDR_W+$clog2(DATA_W/8)-1:0] ev_addr_o,
   output logic [DATA_W-1:0]         ev_data_o,
   output logic [DATA_W-1:0]         ev_mask_o,
   output logic                      ev_collide_o
);
   localparam int NCH    = DATA_W / CHUNK_W;
   localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int OFFS_W = $clog2(DATA_W / 8);
   localparam int CB_SH  = $clog2(CHUNK_W / 8);
   localparam int BA_W   = ADDR_W + OFFS_W;

   // elaboration-time parameter checks
   if (DATA_W % CHUNK_W != 0) begin : g_bad_div
      $error("DATA_W must be a multiple of CHUNK_W");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("at least two chunks per line are needed");
   end
   if ((CHUNK_W % 8 != 0) || ((1 << CB_SH) != CHUNK_W / 8)) begin : g_bad_chunk
      $error("CHUNK_W must be a power-of-two number of bytes");
   end
   if ((1 << OFFS_W) != DATA_W / 8) begin : g_bad_line
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic [NCH-1:0]    ch_full;
   logic [NCH-1:0]    ch_touch;
   logic [IDX_W-1:0]  ch_idx;
   logic              ch_single;
   ev_kind_e          kind_d;
   logic              valid_d;
   logic              collide_d;
   logic [BA_W-1:0]   addr_d;
   logic [DATA_W-1:0] data_d;
   logic [DATA_W-1:0] mask_d;

   dwc_chunk_scan #(
      .DATA_W  (DATA_W),
      .CHUNK_W (CHUNK_W)
   ) u_scan (
      .mask_i  (wmask_i),
      .full_o  (ch_full),
      .touch_o (ch_touch)
   );

   dwc_onehot_index #(
      .N     (NCH),
      .IDX_W (IDX_W)
   ) u_index (
      .vec_i    (ch_touch),
      .idx_o    (ch_idx),
      .single_o (ch_single)
   );

   dwc_classify #(
      .NCH (NCH)
   ) u_class (
      .wr_en_i        (wr_en_i),
      .rd_en_i        (rd_en_i),
      .full_i         (ch_full),
      .touch_i        (ch_touch),
      .single_touch_i (ch_single),
      .kind_o         (kind_d),
      .valid_o        (valid_d),
      .collide_o      (collide_d)
   );

   dwc_payload #(
      .DATA_W  (DATA_W),
      .CHUNK_W (CHUNK_W),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .OFFS_W  (OFFS_W),
      .CB_SH   (CB_SH)
   ) u_payload (
      .kind_i  (kind_d),
      .idx_i   (ch_idx),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .wmask_i (wmask_i),
      .rdata_i (rdata_i),
      .baddr_o (addr_d),
      .data_o  (data_d),
      .mask_o  (mask_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ev_valid_o   <= 1'b0;
         ev_collide_o <= 1'b0;
         ev_kind_o    <= EV_FULL;
         ev_addr_o    <= '0;
         ev_data_o    <= '0;
         ev_mask_o    <= '0;
      end else begin
         ev_valid_o   <= valid_d;
         ev_collide_o <= collide_d;
         if (valid_d) begin
            ev_kind_o <= kind_d;
            ev_addr_o <= addr_d;
            ev_data_o <= data_d;
            ev_mask_o <= mask_d;
         end
      end
   end
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker
   import dwc_pkg::*;
#(
   parameter int DATA_W  = 256,
   parameter int CHUNK_W = 32,
   parameter int ADDR_W  = 10
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      wr_en_i,
   input logic                      rd_en_i,
   input logic [ADDR_W-1:0]         addr_i,
   input logic [DATA_W-1:0]         wdata_i,
   input logic [DATA_W-1:0]         wmask_i,
   input logic [DATA_W-1:0]         rdata_i,
   input logic                      ev_valid_o,
   input logic [1:0]                ev_kind_o,
   input logic [ADDR_W+$clog2(DATA_W/8)-1:0] ev_addr_o,
   input logic [DATA_W-1:0]         ev_data_o,
   input logic [DATA_W-1:0]         ev_mask_o,
   input logic                      ev_collide_o
);
   localparam int OFFS_W = $clog2(DATA_W / 8);
   localparam int CB_SH  = $clog2(CHUNK_W / 8);
   localparam int BA_W   = ADDR_W + OFFS_W;

   p_full_shape_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wmask_i == '1)) |=>
         (ev_valid_o && ev_kind_o == EV_FULL &&
          ev_addr_o == {$past(addr_i), {OFFS_W{1'b0}}} && ev_data_o == $past(wdata_i)));

   p_word_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_o && ev_kind_o == EV_WORD) |->
         (ev_data_o[DATA_W-1:CHUNK_W] == '0 && ev_mask_o == '0));

   p_word_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_o && ev_kind_o == EV_WORD) |->
         (ev_addr_o[CB_SH-1:0] == '0 && ev_addr_o[BA_W-1:OFFS_W] == $past(addr_i)));

   p_err_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_o && ev_kind_o == EV_ERR) |->
         (ev_mask_o == $past(wmask_i) && ev_data_o == $past(wdata_i)));

   p_zero_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wmask_i == '0)) |=> (ev_valid_o && ev_kind_o == EV_ERR));

   p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !wr_en_i) |=>
         (ev_valid_o && ev_kind_o == EV_LOAD && ev_data_o == $past(rdata_i) &&
          ev_addr_o == {$past(addr_i), {OFFS_W{1'b0}}}));

   p_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_collide_o |-> (ev_valid_o && ev_kind_o != EV_LOAD));

   p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !rd_en_i) |=> (!ev_valid_o && !ev_collide_o));
endmodule

bind dmem_wr_classify dwc_checker #(
   .DATA_W  (DATA_W),
   .CHUNK_W (CHUNK_W),
   .ADDR_W  (ADDR_W)
) u_dwc_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .rd_en_i      (rd_en_i),
   .addr_i       (addr_i),
   .wdata_i      (wdata_i),
   .wmask_i      (wmask_i),
   .rdata_i      (rdata_i),
   .ev_valid_o   (ev_valid_o),
   .ev_kind_o    (ev_kind_o),
   .ev_addr_o    (ev_addr_o),
   .ev_data_o    (ev_data_o),
   .ev_mask_o    (ev_mask_o),
   .ev_collide_o (ev_collide_o)
);

// File: tb/dmem_wr_classify_bench.sv
`timescale 1ns/1ps
module dmem_wr_classify_bench;
   localparam int DW   = 256;
   localparam int CW   = 32;
   localparam int AW   = 6;
   localparam int NCH  = DW / CW;
   localparam int BA_W = AW + 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] wmask = '0;
   logic [DW-1:0] rdata = '0;
   logic          ev_valid;
   logic [1:0]    ev_kind;
   logic [BA_W-1:0] ev_addr;
   logic [DW-1:0] ev_data;
   logic [DW-1:0] ev_mask;
   logic          ev_collide;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dmem_wr_classify #(.DATA_W(DW), .CHUNK_W(CW), .ADDR_W(AW)) u_dmem_wr_classify (
      .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .rd_en_i (rd_en),
      .addr_i (addr), .wdata_i (wdata), .wmask_i (wmask), .rdata_i (rdata),
      .ev_valid_o (ev_valid), .ev_kind_o (ev_kind), .ev_addr_o (ev_addr),
      .ev_data_o (ev_data), .ev_mask_o (ev_mask), .ev_collide_o (ev_collide)
   );

   function automatic logic [DW-1:0] rnd_line();
      logic [DW-1:0] v;
      for (int i = 0; i < NCH; i++) v[i*CW +: CW] = $urandom();
      return v;
   endfunction

   // Drive one access at a falling edge, let one rising edge register it,
   // then compare at the next falling edge against the requirement model.
   task automatic apply(input logic w, input logic r, input logic [AW-1:0] a,
                        input logic [DW-1:0] m);
      logic [1:0]      k;
      logic [BA_W-1:0] ea;
      logic [DW-1:0]   ed, em;
      int nfull, ntouch, idx;
      string tag;
      logic [DW-1:0] d, rd;
      d  = rnd_line();
      rd = rnd_line();
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wmask = m; wdata = d; rdata = rd;
      nfull = 0; ntouch = 0; idx = 0;
      for (int c = 0; c < NCH; c++) begin
         if (m[c*CW +: CW] == '1) begin nfull++; idx = c; end
         if (m[c*CW +: CW] != '0) ntouch++;
      end
      ea = {a, 5'b0};
      ed = d;
      em = '0;
      if (w) begin
         if (m == '1) begin k = 2'd0; tag = "R2"; end
         else if (nfull == 1 && ntouch == 1) begin
            k = 2'd1; tag = "R3 R4";
            ea = BA_W'({a, 5'b0}) + BA_W'(4 * idx);
            ed = DW'(d[idx*CW +: CW]);
         end else begin
            k = 2'd2; em = m;
            tag = (m == '0) ? "R6" : "R5";
         end
         if (r) tag = {tag, " R8"};
      end else begin
         k = 2'd3; ed = rd; tag = "R7";
      end
      if (!w && !r) tag = "R9";
      @(negedge clk);
      n_vec++;
      if (!w && !r) begin
         if (ev_valid !== 1'b0 || ev_collide !== 1'b0) begin
            n_bad++;
            $display("FAIL %s idle: valid=%0b collide=%0b expected 0 0", tag, ev_valid, ev_collide);
         end
      end else if (ev_valid !== 1'b1 || ev_kind !== k || ev_addr !== ea ||
                   ev_data !== ed || ev_mask !== em || ev_collide !== (w & r)) begin
         n_bad++;
         $display("FAIL %s: valid=%0b kind=%0d addr=%h collide=%0b data=%h mask=%h | expected valid=1 kind=%0d addr=%h collide=%0b data=%h mask=%h",
                  tag, ev_valid, ev_kind, ev_addr, ev_collide, ev_data, ev_mask,
                  k, ea, w & r, ed, em);
      end
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   function automatic logic [DW-1:0] chunks_to_mask(input logic [NCH-1:0] sel);
      logic [DW-1:0] m = '0;
      for (int c = 0; c < NCH; c++) if (sel[c]) m[c*CW +: CW] = '1;
      return m;
   endfunction

   initial begin : watchdog
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      n_vec++;
      if (ev_valid !== 1'b0 || ev_collide !== 1'b0) begin  // R1 during reset
         n_bad++;
         $display("FAIL R1 in reset: valid=%0b collide=%0b expected 0 0", ev_valid, ev_collide);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (ev_valid !== 1'b0 || ev_collide !== 1'b0) begin  // R1 after release
         n_bad++;
         $display("FAIL R1 after reset: valid=%0b collide=%0b expected 0 0", ev_valid, ev_collide);
      end
      // R2: full lines at corner addresses
      apply(1, 0, '0, '1);
      apply(1, 0, '1, '1);
      apply(1, 0, AW'(21), '1);
      // R3 R4: every chunk at several addresses
      for (int c = 0; c < NCH; c++)
         for (int a = 0; a < 4; a++)
            apply(1, 0, AW'(a * 17 + 5), chunks_to_mask(NCH'(1) << c));
      // R5 R6: every subset of whole chunks, including none and all
      for (int s = 0; s < (1 << NCH); s++)
         apply(1, 0, AW'(s), chunks_to_mask(NCH'(s)));
      // R5: one bit missing and one bit alone in each chunk
      for (int b = 0; b < DW; b++) begin
         logic [DW-1:0] one;
         one = DW'(1) << b;
         apply(1, 0, AW'(b), chunks_to_mask(NCH'(1) << (b / CW)) & ~one);
         apply(1, 0, AW'(b), one);
      end
      // R5: 32-bit windows that straddle a chunk boundary
      for (int sh = 1; sh < DW - CW; sh += 7)
         if (sh % CW != 0) apply(1, 0, AW'(sh), DW'({CW{1'b1}}) << sh);
      // R7: loads
      for (int a = 0; a < 8; a++) apply(0, 1, AW'(a * 9), '0);
      apply(0, 1, AW'(3), '1);
      // R8: read and write together
      apply(1, 1, AW'(7), '1);
      apply(1, 1, AW'(8), chunks_to_mask(NCH'(4)));
      apply(1, 1, AW'(9), DW'(3));
      apply(1, 1, AW'(10), '0);
      // R9: idle cycles
      apply(0, 0, AW'(1), '1);
      apply(0, 0, AW'(2), '0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule